// File: doc/BRIEF.md
# Serial Transceiver with Line Flow Control

This block is a full-duplex asynchronous serial transceiver. Each character is 8 data bits with no parity bit. A divider input sets the bit time. Outgoing bytes enter through a valid/ready stream and are parked in a one-entry holding slot. Incoming bytes go through a glitch filter and a 16x-oversampled receiver, then into an 8-entry queue. That queue drains through a second valid/ready stream.

Two flow-control schemes can be switched on independently:

- **Hardware handshake.** A clear-to-send input gates the start of each new character. A request-to-send output tells the far end to stop while the receive queue is close to full.
- **Software handshake.** Received XOFF (0x13) and XON (0x11) bytes pause and resume outgoing data, and they are never stored. The block also sends XOFF and XON on its own as its receive queue fills and drains.

For block sends, a programmable number of idle bit times is placed between characters. Completion of the last character raises a maskable pulse.

Back-pressure rules:

- **Transmit stream.** `tx_ready` is high exactly when the holding slot is empty. A byte is taken on a clock edge where both `tx_valid` and `tx_ready` are high. The source may hold `tx_valid` high with stable data for any time.
- **Receive stream.** `rx_valid` is high while the queue is non-empty, and `rx_data` shows the oldest byte. That byte is removed on an edge where both `rx_valid` and `rx_ready` are high. A sink that holds `rx_ready` low lets the queue fill; bytes that then arrive are lost (see R8).

Top module: `flowctl_uart`

## Requirements
- R1: The transmit line idles high. A character is one low start bit, then 8 data bits LSB first with no parity, then stop bit(s) at high. Every bit lasts 16*(cfg_div+1) clock cycles.
- R2: With cfg_two_stop=0 one stop bit is sent, so back-to-back characters start 10 bit times apart. With cfg_two_stop=1 two stop bits are sent, so they start 11 bit times apart.
- R3: A data character accepted with tx_last=0 is followed by cfg_gap idle bit times before the next character starts. After a character with tx_last=1, the next one may start immediately.
- R4: irq_blk_done pulses high for one cycle when a data character accepted with tx_last=1 finishes its final stop bit, provided cfg_blk_irq_en=1. When cfg_blk_irq_en=0 it stays low.
- R5: After reset, ser_tx=1, tx_ready=1, rx_valid=0, rts_n=0, and both interrupts are low. tx_ready follows the emptiness of the one-entry holding slot.
- R6: The receiver samples each bit at mid-bit and needs one stop bit. Good bytes enter an 8-entry queue and leave on rx_data in arrival order. irq_rx equals cfg_rx_irq_en AND rx_valid.
- R7: If the stop bit is sampled low, rx_frame_err pulses for one cycle and the byte is discarded.
- R8: If a byte completes while the queue holds 8 entries, rx_overrun pulses for one cycle and the byte is discarded. The stored bytes are unchanged.
- R9: A low pulse on ser_rx shorter than FILT_LEN (default 4) clock cycles never starts a frame.
- R10: With cfg_hw_flow=1 and cts_n high, no new character starts. A character already in progress completes normally.
- R11: With cfg_hw_flow=1, rts_n goes high once the queue holds 6 entries and goes low again once it drains to 2. With cfg_hw_flow=0, rts_n stays low.
- R12: With cfg_sw_flow=1, a received 0x13 pauses data characters and a received 0x11 resumes them; neither byte is queued. With cfg_sw_flow=0, both are queued as ordinary data.
- R13: With cfg_sw_flow=1, the block sends 0x13 when its queue reaches 6 entries and 0x11 when it drains back to 2. These control characters ignore the pause, skip the gap, and go ahead of held data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 16 | Bit time divider; bit = 16*(cfg_div+1) clocks |
| cfg_two_stop | input | 1 | Send two stop bits |
| cfg_gap | input | 4 | Idle bit times between block characters |
| cfg_hw_flow | input | 1 | Enable CTS/RTS handshake |
| cfg_sw_flow | input | 1 | Enable XON/XOFF handshake |
| cfg_rx_irq_en | input | 1 | Mask for receive interrupt |
| cfg_blk_irq_en | input | 1 | Mask for block-done interrupt |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Holding slot empty |
| tx_data | input | 8 | Transmit byte |
| tx_last | input | 1 | Byte ends a block |
| rx_valid | output | 1 | Queue non-empty |
| rx_ready | input | 1 | Sink takes the head byte |
| rx_data | output | 8 | Oldest received byte |
| ser_tx | output | 1 | Serial transmit line |
| ser_rx | input | 1 | Serial receive line |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |
| irq_rx | output | 1 | Receive data available interrupt |
| irq_blk_done | output | 1 | Block transmit done pulse |
| rx_frame_err | output | 1 | Framing error pulse |
| rx_overrun | output | 1 | Overrun pulse |

## Verification
Faults in the bit counters or in the stop or gap sequencing show up on ser_tx within one character. They appear as a misread data bit, a low stop bit, or a start-to-start spacing that is off by whole multiples of 16 clocks. These faults are caught by decoding the line at mid-bit and timing the distance between start edges.

A wrong queue pointer or count reaches rx_data, rx_overrun or rts_n as soon as the queue is drained or filled past its marks. A stuck pause or flow flag shows up as ser_tx staying idle for hundreds of cycles while data is held, or as a missing control character.

// File: rtl/fu_pkg.sv
package fu_pkg;
  localparam logic [7:0] CH_XON  = 8'h11;
  localparam logic [7:0] CH_XOFF = 8'h13;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_STOP,
    TX_GAP
  } tx_state_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;
endpackage

// File: rtl/fu_baud.sv
module fu_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  // one tick per 1/16 bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/fu_rx.sv
module fu_rx
  import fu_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  output logic       byte_done,
  output logic [7:0] byte_data,
  output logic       frame_err
);
  localparam int FW = $clog2(FILT_LEN + 1);

  logic          s1, s2, line;
  logic [FW-1:0] fcnt;
  rx_state_t     st;
  logic [3:0]    tcnt;
  logic [2:0]    bidx;
  logic [7:0]    shr;

  assign byte_data = shr;

  // synchronizer and glitch filter: line follows only a level held FILT_LEN clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      line <= 1'b1;
      fcnt <= '0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      if (s2 == line) begin
        fcnt <= '0;
      end else if (fcnt == FW'(FILT_LEN - 1)) begin
        line <= s2;
        fcnt <= '0;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      shr       <= '0;
      byte_done <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      frame_err <= 1'b0;
      unique case (st)
        RX_IDLE: begin
          tcnt <= '0;
          if (!line) st <= RX_START;
        end
        RX_START: if (tick) begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == 4'd7) begin
            tcnt <= '0;
            bidx <= '0;
            st   <= line ? RX_IDLE : RX_DATA;   // false start is dropped
          end
        end
        RX_DATA: if (tick) begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == 4'hF) begin
            shr  <= {line, shr[7:1]};
            bidx <= bidx + 1'b1;
            if (bidx == 3'd7) st <= RX_STOP;
          end
        end
        RX_STOP: if (tick) begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == 4'hF) begin
            byte_done <= line;
            frame_err <= !line;
            st        <= RX_IDLE;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  assert_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_done && frame_err));

  assert_filter_settled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (line != $past(line)) |-> (line == $past(s2)));
endmodule

// File: rtl/fu_rxq.sv
module fu_rxq #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      unique case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/fu_tx.sv
module fu_tx
  import fu_pkg::*;
#(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             two_stop,
  input  logic [GAP_W-1:0] gap,
  input  logic             src_valid,
  input  logic [7:0]       src_data,
  input  logic             src_ctrl,
  input  logic             src_last,
  output logic             src_take,
  output logic             txd,
  output logic             last_done
);
  tx_state_t        st;
  logic [3:0]       tcnt;
  logic [2:0]       bidx;
  logic [7:0]       shr;
  logic             cur_last, cur_ctrl, stop_more;
  logic [GAP_W-1:0] gcnt;
  logic             bit_end, need_gap, stop_end, gap_end, free;

  always_comb begin
    bit_end  = tick && (tcnt == 4'hF);
    need_gap = !cur_ctrl && !cur_last && (gap != '0);
    stop_end = (st == TX_STOP) && bit_end && !stop_more;
    gap_end  = (st == TX_GAP) && bit_end && (gcnt == GAP_W'(1));
    free     = (st == TX_IDLE) || (stop_end && !need_gap) || gap_end;
    src_take = free && src_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= TX_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      shr       <= '0;
      cur_last  <= 1'b0;
      cur_ctrl  <= 1'b0;
      stop_more <= 1'b0;
      gcnt      <= '0;
      txd       <= 1'b1;
      last_done <= 1'b0;
    end else begin
      last_done <= stop_end && cur_last && !cur_ctrl;
      if (tick) tcnt <= tcnt + 1'b1;
      if (src_take) begin
        st        <= TX_START;
        shr       <= src_data;
        cur_last  <= src_last;
        cur_ctrl  <= src_ctrl;
        stop_more <= two_stop;
        tcnt      <= '0;
        txd       <= 1'b0;
      end else begin
        unique case (st)
          TX_IDLE: txd <= 1'b1;
          TX_START: if (bit_end) begin
            txd  <= shr[0];
            shr  <= shr >> 1;
            bidx <= '0;
            st   <= TX_DATA;
          end
          TX_DATA: if (bit_end) begin
            if (bidx == 3'd7) begin
              txd <= 1'b1;
              st  <= TX_STOP;
            end else begin
              txd  <= shr[0];
              shr  <= shr >> 1;
              bidx <= bidx + 1'b1;
            end
          end
          TX_STOP: if (bit_end) begin
            if (stop_more) begin
              stop_more <= 1'b0;
            end else if (need_gap) begin
              gcnt <= gap;
              st   <= TX_GAP;
            end else begin
              st <= TX_IDLE;
            end
          end
          TX_GAP: if (bit_end) begin
            if (gcnt == GAP_W'(1)) st <= TX_IDLE;
            else gcnt <= gcnt - 1'b1;
          end
          default: st <= TX_IDLE;
        endcase
      end
    end
  end

  assert_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_IDLE || st == TX_STOP || st == TX_GAP) |-> txd);

  assert_done_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last_done |-> $past(st == TX_STOP));
endmodule

// File: rtl/flowctl_uart.sv
module flowctl_uart
  import fu_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int GAP_W    = 4,
  parameter int DEPTH    = 8,
  parameter int FILT_LEN = 4,
  parameter int HI_MARK  = 6,
  parameter int LO_MARK  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_two_stop,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic             cfg_hw_flow,
  input  logic             cfg_sw_flow,
  input  logic             cfg_rx_irq_en,
  input  logic             cfg_blk_irq_en,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  input  logic             tx_last,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  output logic             ser_tx,
  input  logic             ser_rx,
  input  logic             cts_n,
  output logic             rts_n,
  output logic             irq_rx,
  output logic             irq_blk_done,
  output logic             rx_frame_err,
  output logic             rx_overrun
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          tick;
  logic          rx_done, rx_ferr;
  logic [7:0]    rx_byte;
  logic          q_full, q_empty, q_push, q_pop;
  logic [CW-1:0] q_count;
  logic          is_ctl;
  logic          cts_s1, cts_s2;
  logic          paused, xoff_req, xon_req, remote_off;
  logic          hold_valid, hold_last;
  logic [7:0]    hold_data;
  logic          src_valid, src_ctrl, src_last, src_take, last_done;
  logic [7:0]    src_data;

  fu_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick)
  );

  fu_rx #(.FILT_LEN(FILT_LEN)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(ser_rx),
    .byte_done(rx_done), .byte_data(rx_byte), .frame_err(rx_ferr)
  );

  // receive path
  assign is_ctl       = cfg_sw_flow && (rx_byte == CH_XON || rx_byte == CH_XOFF);
  assign q_push       = rx_done && !is_ctl && !q_full;
  assign rx_overrun   = rx_done && !is_ctl && q_full;
  assign rx_frame_err = rx_ferr;
  assign q_pop        = rx_valid && rx_ready;
  assign rx_valid     = !q_empty;
  assign irq_rx       = cfg_rx_irq_en && rx_valid;

  fu_rxq #(.DEPTH(DEPTH), .W(8)) u_q (
    .clk(clk), .rst_n(rst_n), .push(q_push), .din(rx_byte), .pop(q_pop),
    .dout(rx_data), .full(q_full), .empty(q_empty), .count(q_count)
  );

  // flow control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_s1     <= 1'b1;
      cts_s2     <= 1'b1;
      rts_n      <= 1'b0;
      paused     <= 1'b0;
      xoff_req   <= 1'b0;
      xon_req    <= 1'b0;
      remote_off <= 1'b0;
    end else begin
      cts_s1 <= cts_n;
      cts_s2 <= cts_s1;

      if (!cfg_hw_flow)                  rts_n <= 1'b0;
      else if (q_count >= CW'(HI_MARK))  rts_n <= 1'b1;
      else if (q_count <= CW'(LO_MARK))  rts_n <= 1'b0;

      if (!cfg_sw_flow) begin
        paused     <= 1'b0;
        xoff_req   <= 1'b0;
        xon_req    <= 1'b0;
        remote_off <= 1'b0;
      end else begin
        if (rx_done && rx_byte == CH_XOFF) paused <= 1'b1;
        if (rx_done && rx_byte == CH_XON)  paused <= 1'b0;
        if (src_take && xoff_req)     xoff_req <= 1'b0;
        else if (src_take && xon_req) xon_req  <= 1'b0;
        if (!remote_off && q_count >= CW'(HI_MARK)) begin
          xoff_req   <= 1'b1;
          xon_req    <= 1'b0;
          remote_off <= 1'b1;
        end else if (remote_off && q_count <= CW'(LO_MARK)) begin
          xon_req    <= 1'b1;
          remote_off <= 1'b0;
        end
      end
    end
  end

  // transmit holding slot and source selection
  assign tx_ready = !hold_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_last  <= 1'b0;
      hold_data  <= '0;
    end else if (tx_valid && tx_ready) begin
      hold_valid <= 1'b1;
      hold_last  <= tx_last;
      hold_data  <= tx_data;
    end else if (src_take && !src_ctrl) begin
      hold_valid <= 1'b0;
    end
  end

  always_comb begin
    src_ctrl  = xoff_req || xon_req;
    src_data  = xoff_req ? CH_XOFF : (xon_req ? CH_XON : hold_data);
    src_last  = !src_ctrl && hold_last;
    src_valid = !(cfg_hw_flow && cts_s2) &&
                (src_ctrl || (hold_valid && !(cfg_sw_flow && paused)));
  end

  fu_tx #(.GAP_W(GAP_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .two_stop(cfg_two_stop), .gap(cfg_gap),
    .src_valid(src_valid), .src_data(src_data), .src_ctrl(src_ctrl), .src_last(src_last),
    .src_take(src_take), .txd(ser_tx), .last_done(last_done)
  );

  assign irq_blk_done = cfg_blk_irq_en && last_done;

  assert_cts_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hw_flow && cts_s2) |-> !src_take);

  assert_pause_ctrl_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sw_flow && paused && src_take) |-> src_ctrl);

  assert_ctl_dropped_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && is_ctl) |=> (q_count <= $past(q_count)));

  assert_rts_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hw_flow && q_count >= CW'(HI_MARK)) |=> (rts_n || !cfg_hw_flow));
endmodule

// File: tb/flowctl_uart_tb.sv
module flowctl_uart_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_div = '0;
  logic        cfg_two_stop = 1'b0;
  logic [3:0]  cfg_gap = '0;
  logic        cfg_hw_flow = 1'b0, cfg_sw_flow = 1'b0;
  logic        cfg_rx_irq_en = 1'b1, cfg_blk_irq_en = 1'b1;
  logic        tx_valid = 1'b0, tx_last = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_ready, rx_valid;
  logic        rx_ready = 1'b0;
  logic [7:0]  rx_data;
  logic        ser_tx;
  logic        ser_rx = 1'b1;
  logic        cts_n = 1'b0;
  logic        rts_n, irq_rx, irq_blk_done, rx_frame_err, rx_overrun;

  int nvec = 0, nbad = 0, cyc = 0;
  int blk_cnt = 0, ferr_cnt = 0, ovr_cnt = 0;

  always #10 clk = ~clk;

  flowctl_uart u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_two_stop(cfg_two_stop),
    .cfg_gap(cfg_gap), .cfg_hw_flow(cfg_hw_flow), .cfg_sw_flow(cfg_sw_flow),
    .cfg_rx_irq_en(cfg_rx_irq_en), .cfg_blk_irq_en(cfg_blk_irq_en),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .ser_tx(ser_tx), .ser_rx(ser_rx), .cts_n(cts_n), .rts_n(rts_n),
    .irq_rx(irq_rx), .irq_blk_done(irq_blk_done),
    .rx_frame_err(rx_frame_err), .rx_overrun(rx_overrun)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (irq_blk_done) blk_cnt++;
    if (rx_frame_err) ferr_cnt++;
    if (rx_overrun)   ovr_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_tx(input logic [7:0] d, input bit l);
    tx_data = d; tx_last = l; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic get_frame(output logic [7:0] d, output int t0, output bit ok);
    int w = 0;
    ok = 1'b1; d = '0; t0 = 0;
    @(negedge clk);
    while (ser_tx && w < 6000) begin @(negedge clk); w++; end
    if (ser_tx) begin ok = 1'b0; return; end
    t0 = cyc;
    repeat (8) @(negedge clk);
    if (ser_tx) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (16) @(negedge clk);
      d[i] = ser_tx;
    end
    repeat (16) @(negedge clk);
    if (!ser_tx) ok = 1'b0;
  endtask

  task automatic drive_rx(input logic [7:0] d, input bit stop_bit);
    ser_rx = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ser_rx = d[i];
      repeat (16) @(negedge clk);
    end
    ser_rx = stop_bit;
    repeat (16) @(negedge clk);
    ser_rx = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic pop_rx(output logic [7:0] d);
    d = rx_data;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic watch_idle(input int n, output bit stayed);
    stayed = 1'b1;
    repeat (n) begin
      @(negedge clk);
      if (!ser_tx) stayed = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk(ser_tx == 1'b1, "R5 reset ser_tx", ser_tx, 1);
    chk(tx_ready == 1'b1, "R5 reset tx_ready", tx_ready, 1);
    chk(rx_valid == 1'b0, "R5 reset rx_valid", rx_valid, 0);
    chk(rts_n == 1'b0, "R5 reset rts_n", rts_n, 0);
    chk(irq_rx == 1'b0 && irq_blk_done == 1'b0, "R5 reset irqs", {irq_rx, irq_blk_done}, 0);
  endtask

  task automatic t_basic_tx();
    logic [7:0] d; int t0; bit ok;
    blk_cnt = 0;
    fork
      push_tx(8'hA5, 1'b1);
      get_frame(d, t0, ok);
    join
    chk(ok && d == 8'hA5, "R1 frame data", d, 8'hA5);
    repeat (20) @(negedge clk);
    chk(blk_cnt == 1, "R4 done pulse", blk_cnt, 1);
  endtask

  task automatic t_stops(input bit two, input int exp_gap);
    logic [7:0] d0, d1; int t0, t1; bit ok0, ok1;
    cfg_two_stop = two;
    fork
      begin push_tx(8'h3C, 1'b1); push_tx(8'hC3, 1'b1); end
      begin get_frame(d0, t0, ok0); get_frame(d1, t1, ok1); end
    join
    chk(ok0 && ok1 && d0 == 8'h3C && d1 == 8'hC3, "R2 frame pair", {d0, d1}, 16'h3CC3);
    chk((t1 - t0) >= exp_gap - 1 && (t1 - t0) <= exp_gap + 1, "R2 start spacing", t1 - t0, exp_gap);
    repeat (40) @(negedge clk);
    cfg_two_stop = 1'b0;
  endtask

  task automatic t_gap();
    logic [7:0] d0, d1; int t0, t1; bit ok0, ok1;
    cfg_gap = 4'd3; blk_cnt = 0;
    fork
      begin push_tx(8'h11, 1'b0); push_tx(8'h96, 1'b1); end
      begin get_frame(d0, t0, ok0); get_frame(d1, t1, ok1); end
    join
    chk(ok0 && ok1 && d1 == 8'h96, "R3 gap frames", d1, 8'h96);
    chk((t1 - t0) >= 207 && (t1 - t0) <= 209, "R3 gap spacing", t1 - t0, 208);
    repeat (20) @(negedge clk);
    chk(blk_cnt == 1, "R4 one pulse per block", blk_cnt, 1);
    cfg_blk_irq_en = 1'b0; blk_cnt = 0;
    fork
      push_tx(8'h01, 1'b1);
      get_frame(d0, t0, ok0);
    join
    repeat (20) @(negedge clk);
    chk(blk_cnt == 0, "R4 masked", blk_cnt, 0);
    cfg_blk_irq_en = 1'b1; cfg_gap = '0;
  endtask

  task automatic t_rx_basic();
    logic [7:0] d;
    drive_rx(8'h3C, 1'b1);
    chk(rx_valid && rx_data == 8'h3C, "R6 rx byte", rx_data, 8'h3C);
    chk(irq_rx == 1'b1, "R6 irq_rx on", irq_rx, 1);
    cfg_rx_irq_en = 1'b0; @(negedge clk);
    chk(irq_rx == 1'b0, "R6 irq_rx masked", irq_rx, 0);
    cfg_rx_irq_en = 1'b1;
    pop_rx(d);
    chk(!rx_valid, "R6 empty after pop", rx_valid, 0);
    drive_rx(8'h13, 1'b1);
    chk(rx_valid && rx_data == 8'h13, "R12 xoff stored when sw off", rx_data, 8'h13);
    pop_rx(d);
  endtask

  task automatic t_frame_err();
    ferr_cnt = 0;
    drive_rx(8'h55, 1'b0);
    repeat (30) @(negedge clk);
    chk(ferr_cnt == 1, "R7 frame err pulse", ferr_cnt, 1);
    chk(!rx_valid, "R7 byte dropped", rx_valid, 0);
  endtask

  task automatic t_glitch();
    logic [7:0] d;
    ferr_cnt = 0;
    ser_rx = 1'b0; repeat (3) @(negedge clk); ser_rx = 1'b1;
    repeat (400) @(negedge clk);
    chk(!rx_valid && ferr_cnt == 0, "R9 glitch ignored", {rx_valid, ferr_cnt[0]}, 0);
    drive_rx(8'h81, 1'b1);
    chk(rx_valid && rx_data == 8'h81, "R9 byte after glitch", rx_data, 8'h81);
    pop_rx(d);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    ovr_cnt = 0;
    for (int i = 0; i < 9; i++) drive_rx(8'h40 + 8'(i), 1'b1);
    chk(ovr_cnt == 1, "R8 overrun pulse", ovr_cnt, 1);
    for (int i = 0; i < 8; i++) begin
      pop_rx(d);
      chk(d == 8'h40 + 8'(i), "R8 kept order", d, 8'h40 + i);
    end
    chk(!rx_valid, "R8 ninth lost", rx_valid, 0);
  endtask

  task automatic t_rts();
    logic [7:0] d;
    cfg_hw_flow = 1'b1;
    for (int i = 0; i < 5; i++) drive_rx(8'h60 + 8'(i), 1'b1);
    chk(rts_n == 1'b0, "R11 rts low at 5", rts_n, 0);
    drive_rx(8'h65, 1'b1);
    chk(rts_n == 1'b1, "R11 rts high at 6", rts_n, 1);
    for (int i = 0; i < 3; i++) pop_rx(d);
    @(negedge clk);
    chk(rts_n == 1'b1, "R11 rts stays high at 3", rts_n, 1);
    pop_rx(d); @(negedge clk);
    chk(rts_n == 1'b0, "R11 rts low at 2", rts_n, 0);
    pop_rx(d); pop_rx(d);
    cfg_hw_flow = 1'b0;
  endtask

  task automatic t_cts();
    logic [7:0] d; int t0; bit ok, idle;
    cfg_hw_flow = 1'b1;
    fork
      push_tx(8'h5A, 1'b1);
      get_frame(d, t0, ok);
      begin
        @(negedge clk); while (ser_tx) @(negedge clk);
        repeat (40) @(negedge clk);
        cts_n = 1'b1;
      end
    join
    chk(ok && d == 8'h5A, "R10 in-progress completes", d, 8'h5A);
    push_tx(8'hE7, 1'b1);
    watch_idle(300, idle);
    chk(idle, "R10 held while cts high", idle, 1);
    fork
      cts_n = 1'b0;
      get_frame(d, t0, ok);
    join
    chk(ok && d == 8'hE7, "R10 resumes", d, 8'hE7);
    repeat (40) @(negedge clk);
    cfg_hw_flow = 1'b0;
  endtask

  task automatic t_xonxoff();
    logic [7:0] d; int t0; bit ok, idle;
    cfg_sw_flow = 1'b1;
    drive_rx(8'h13, 1'b1);
    chk(!rx_valid, "R12 xoff not stored", rx_valid, 0);
    push_tx(8'h4B, 1'b1);
    watch_idle(300, idle);
    chk(idle, "R12 paused by xoff", idle, 1);
    fork
      drive_rx(8'h11, 1'b1);
      get_frame(d, t0, ok);
    join
    chk(ok && d == 8'h4B, "R12 resumed by xon", d, 8'h4B);
    chk(!rx_valid, "R12 xon not stored", rx_valid, 0);
    repeat (40) @(negedge clk);
  endtask

  task automatic t_auto();
    logic [7:0] d, r; int t0; bit ok;
    fork
      for (int i = 0; i < 6; i++) drive_rx(8'h20 + 8'(i), 1'b1);
      get_frame(d, t0, ok);
    join
    chk(ok && d == 8'h13, "R13 auto xoff", d, 8'h13);
    repeat (200) @(negedge clk);
    fork
      for (int i = 0; i < 4; i++) pop_rx(r);
      get_frame(d, t0, ok);
    join
    chk(ok && d == 8'h11, "R13 auto xon", d, 8'h11);
    pop_rx(r); pop_rx(r);
    chk(!rx_valid, "R13 queue drained", rx_valid, 0);
    cfg_sw_flow = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic_tx();
    t_stops(1'b0, 160);
    t_stops(1'b1, 176);
    t_gap();
    t_rx_basic();
    t_frame_err();
    t_glitch();
    t_overrun();
    t_rts();
    t_cts();
    t_xonxoff();
    t_auto();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule